// File: doc/BRIEF.md
# ALU Status Flag Generator

This block performs one integer operation on two operands and produces the result together with a packed 16-bit status word. The operation can be add, add with carry, subtract, subtract with borrow, or one of four logic operations. The operand width is selectable between 8, 16 and 32 bits. The status word reports carry or borrow, low-byte parity, nibble carry, zero, sign and signed overflow, each at a fixed bit position. Three control bits (single-step, interrupt enable and string direction) pass through unchanged into the same word, so downstream logic can write it directly into a machine status register.

Operations enter on a valid/ready stream and leave on another. With the default `REG_OUT = 1`, one output register sits between the two streams. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so full throughput is kept. While the consumer holds `out_ready` low, the presented result and flags stay frozen and no new request is accepted. With `REG_OUT = 0` the block is purely combinational: the ready signal passes straight back and the valid signal passes straight forward.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` is the operation applied to the low `size` bits of the operands. The upper bits are forced to 0. `op_code` values are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 pass operand B. `op_size` values are: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 32 bits.
- R2: `flags[0]` is the carry out of the top bit of the selected size for add and add with carry. For subtract and subtract with borrow it is the borrow, which is 1 when the unsigned minuend is smaller than the subtrahend plus the borrow-in. Add with carry and subtract with borrow use `carry_in`.
- R3: `flags[2]` is 1 when `result[7:0]` holds an even number of ones, and 0 otherwise.
- R4: `flags[4]` is the carry out of bit 3 for adds, and the borrow into bit 4 for subtracts.
- R5: `flags[6]` is 1 exactly when the result at the selected size is all zeros.
- R6: `flags[7]` equals the top bit of the result at the selected size (bit 7, 15 or 31).
- R7: `flags[11]` is 1 when the exact signed result leaves the signed range of the selected size: -128..127, -32768..32767, or -2147483648..2147483647.
- R8: `flags[8]`, `flags[9]` and `flags[10]` copy `ctrl_in[0]` (single-step), `ctrl_in[1]` (interrupt enable) and `ctrl_in[2]` (direction), whatever the operation.
- R9: `flags[1]` reads 1. `flags[3]`, `flags[5]` and `flags[15:12]` read 0.
- R10: Logic operations (codes 4 to 7) force `flags[0]`, `flags[4]` and `flags[11]` to 0 and still update parity, zero and sign.
- R11: While `out_valid` is high and `out_ready` is low, `result` and `flags` hold and `out_valid` stays high. `in_ready` equals `!out_valid || out_ready`. Results leave in the order the requests were accepted.
- R12: During and straight after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| op_a | input | 32 | First operand (minuend for subtracts) |
| op_b | input | 32 | Second operand (subtrahend for subtracts) |
| carry_in | input | 1 | Carry or borrow input for codes 1 and 3 |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand size select |
| ctrl_in | input | 3 | Pass-through bits for flags 8, 9, 10 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Size-masked result |
| flags | output | 16 | Packed status word |

## Verification
Three kinds of event can fall in the same cycle: a new request being accepted, the held result being drained, and a consumer stall. The bench drives `out_ready` with an irregular pattern, including back-to-back drains and multi-cycle stalls, and leaves gaps in `in_valid`. This makes the output register load a new result on the same edge it hands the old one over, and also makes it refuse a request while it is full. A behavioural queue model computes every expected result with wide signed integer arithmetic and compares each output transfer field by field. A result that is lost, duplicated or changed during a stall therefore shows up as a mismatch against the correct requirement.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;

  localparam int DATA_W    = 32;
  localparam int FLAGS_W   = 16;
  localparam int NUM_SIZES = 3;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SBB   = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_XOR   = 3'd6,
    OP_PASSB = 3'd7
  } alu_op_e;

  localparam int BIT_CARRY  = 0;
  localparam int BIT_ONE    = 1;
  localparam int BIT_PARITY = 2;
  localparam int BIT_AUX    = 4;
  localparam int BIT_ZERO   = 6;
  localparam int BIT_SIGN   = 7;
  localparam int BIT_STEP   = 8;
  localparam int BIT_IEN    = 9;
  localparam int BIT_DIR    = 10;
  localparam int BIT_OVF    = 11;

  typedef struct packed {
    logic carry;
    logic aux;
    logic ovf;
  } arith_flags_t;

  function automatic logic [1:0] size_index(input logic [1:0] sz);
    return (sz == 2'd0) ? 2'd0 : ((sz == 2'd1) ? 2'd1 : 2'd2);
  endfunction

  function automatic logic is_logic_op(input logic [2:0] op);
    return op[2];
  endfunction

endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
module alu_arith
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [2:0]   op,
  input  logic [1:0]   size,
  output logic [W-1:0] res,
  output arith_flags_t fl
);

  logic         invert;
  logic         cin_eff;
  logic [W-1:0] bx;
  logic [4:0]   nib;
  logic [1:0]   sidx;

  logic [W-1:0]         res_k   [NUM_SIZES];
  logic [NUM_SIZES-1:0] carry_k;
  logic [NUM_SIZES-1:0] ovf_k;

  always_comb begin
    invert  = (op == OP_SUB) || (op == OP_SBB);
    unique case (op)
      OP_ADC:  cin_eff = cin;
      OP_SUB:  cin_eff = 1'b1;
      OP_SBB:  cin_eff = ~cin;
      default: cin_eff = 1'b0;
    endcase
    bx = invert ? ~b : b;
  end

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int SW = 8 << k;
    logic [SW:0] s;
    assign s          = {1'b0, a[SW-1:0]} + {1'b0, bx[SW-1:0]} + (SW+1)'(cin_eff);
    assign carry_k[k] = s[SW] ^ invert;
    assign ovf_k[k]   = (a[SW-1] == bx[SW-1]) && (s[SW-1] != a[SW-1]);
    assign res_k[k]   = W'(s[SW-1:0]);
  end

  assign nib  = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + 5'(cin_eff);
  assign sidx = size_index(size);

  always_comb begin
    res      = res_k[sidx];
    fl.carry = carry_k[sidx];
    fl.ovf   = ovf_k[sidx];
    fl.aux   = nib[4] ^ invert;
  end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  input  logic [1:0]   size,
  output logic [W-1:0] res
);

  logic [W-1:0] raw;
  logic [W-1:0] mask;

  always_comb begin
    unique case (op)
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_XOR:  raw = a ^ b;
      default: raw = b;
    endcase
    unique case (size_index(size))
      2'd0:    mask = W'({8{1'b1}});
      2'd1:    mask = W'({16{1'b1}});
      default: mask = {W{1'b1}};
    endcase
    res = raw & mask;
  end

endmodule

// File: rtl/alu_flag_pack.sv
`timescale 1ns/1ps
module alu_flag_pack
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]       res,
  input  logic [1:0]         size,
  input  arith_flags_t       fl,
  input  logic [2:0]         ctrl,
  output logic [FLAGS_W-1:0] word
);

  logic sign_bit;

  always_comb begin
    unique case (size_index(size))
      2'd0:    sign_bit = res[7];
      2'd1:    sign_bit = res[15];
      default: sign_bit = res[W-1];
    endcase
    word             = '0;
    word[BIT_CARRY]  = fl.carry;
    word[BIT_ONE]    = 1'b1;
    word[BIT_PARITY] = ~^res[7:0];
    word[BIT_AUX]    = fl.aux;
    word[BIT_ZERO]   = (res == '0);
    word[BIT_SIGN]   = sign_bit;
    word[BIT_STEP]   = ctrl[0];
    word[BIT_IEN]    = ctrl[1];
    word[BIT_DIR]    = ctrl[2];
    word[BIT_OVF]    = fl.ovf;
  end

endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  input  logic               carry_in,
  input  logic [2:0]         op_code,
  input  logic [1:0]         op_size,
  input  logic [2:0]         ctrl_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  result,
  output logic [FLAGS_W-1:0] flags
);

  logic [DATA_W-1:0]  arith_res;
  logic [DATA_W-1:0]  logic_res;
  logic [DATA_W-1:0]  res_c;
  arith_flags_t       arith_fl;
  arith_flags_t       sel_fl;
  logic [FLAGS_W-1:0] flags_c;
  logic               logic_sel;

  alu_arith #(.W(DATA_W)) u_arith (
    .a(op_a), .b(op_b), .cin(carry_in), .op(op_code), .size(op_size),
    .res(arith_res), .fl(arith_fl)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .a(op_a), .b(op_b), .op(op_code), .size(op_size), .res(logic_res)
  );

  always_comb begin
    logic_sel = is_logic_op(op_code);
    res_c     = logic_sel ? logic_res : arith_res;
    sel_fl    = logic_sel ? '0 : arith_fl;
  end

  alu_flag_pack #(.W(DATA_W)) u_pack (
    .res(res_c), .size(op_size), .fl(sel_fl), .ctrl(ctrl_in), .word(flags_c)
  );

  if (REG_OUT) begin : g_reg
    logic               vld_q;
    logic [DATA_W-1:0]  res_q;
    logic [FLAGS_W-1:0] flg_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign result    = res_q;
    assign flags     = flg_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        flg_q <= FLAGS_W'(1) << BIT_ONE;
      end else if (in_valid && in_ready) begin
        vld_q <= 1'b1;
        res_q <= res_c;
        flg_q <= flags_c;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(result) && $stable(flags)) else $error("stall hold"); // R11
    AST_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> flags[10:8] == $past(ctrl_in)) else $error("ctrl pass"); // R8
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flags[1] && !flags[3] && !flags[5] && (flags[15:12] == 4'd0)) else $error("fixed bits"); // R9
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flags[6] == (result == '0)) else $error("zero flag"); // R5
    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && op_code[2] |=> !flags[0] && !flags[4] && !flags[11]) else $error("logic clear"); // R10
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign result    = res_c;
    assign flags     = flags_c;
  end

endmodule

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  op_size = '0;
  logic [2:0]  ctrl_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] result;
  logic [15:0] flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .op_code(op_code),
    .op_size(op_size), .ctrl_in(ctrl_in), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .flags(flags)
  );

  logic [31:0] exp_r_q[$];
  logic [15:0] exp_f_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic c,
                                input logic [2:0] op, input logic [1:0] sz, input logic [2:0] ct,
                                output logic [31:0] r, output logic [15:0] f);
    int    n;
    longint mask, am, bm, s, sa, sb, smin, smax, sres, half;
    logic  cf, af, of, pf;
    n    = (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
    mask = (longint'(1) << n) - 1;
    half = longint'(1) << (n - 1);
    am   = longint'(a) & mask;
    bm   = longint'(b) & mask;
    sa   = (am >= half) ? am - (longint'(1) << n) : am;
    sb   = (bm >= half) ? bm - (longint'(1) << n) : bm;
    smax = half - 1;
    smin = -half;
    cf = 0; af = 0; of = 0;
    case (op)
      3'd0, 3'd1: begin
        s    = am + bm + ((op == 3'd1) ? longint'(c) : 0);
        cf   = (s > mask);
        af   = ((am & 15) + (bm & 15) + ((op == 3'd1) ? longint'(c) : 0)) > 15;
        sres = sa + sb + ((op == 3'd1) ? longint'(c) : 0);
        of   = (sres > smax) || (sres < smin);
        s    = s & mask;
      end
      3'd2, 3'd3: begin
        s    = (am - bm - ((op == 3'd3) ? longint'(c) : 0)) & mask;
        cf   = am < (bm + ((op == 3'd3) ? longint'(c) : 0));
        af   = (am & 15) < ((bm & 15) + ((op == 3'd3) ? longint'(c) : 0));
        sres = sa - sb - ((op == 3'd3) ? longint'(c) : 0);
        of   = (sres > smax) || (sres < smin);
      end
      3'd4: s = am & bm;
      3'd5: s = am | bm;
      3'd6: s = am ^ bm;
      default: s = bm;
    endcase
    r  = s[31:0];
    pf = 1'b1;
    for (int i = 0; i < 8; i++) if (r[i]) pf = ~pf;
    f      = 16'h0002;
    f[0]   = cf;
    f[2]   = pf;
    f[4]   = af;
    f[6]   = (r == 32'd0);
    f[7]   = r[n-1];
    f[10:8] = ct;
    f[11]  = of;
  endfunction

  task automatic compare_out(input logic [31:0] er, input logic [15:0] ef);
    chk("R1 result", result, er);
    chk("R2 carry bit0", 32'(flags[0]), 32'(ef[0]));
    chk("R3 parity bit2", 32'(flags[2]), 32'(ef[2]));
    chk("R4 aux bit4", 32'(flags[4]), 32'(ef[4]));
    chk("R5 zero bit6", 32'(flags[6]), 32'(ef[6]));
    chk("R6 sign bit7", 32'(flags[7]), 32'(ef[7]));
    chk("R7 overflow bit11", 32'(flags[11]), 32'(ef[11]));
    chk("R8 ctrl bits10:8", 32'(flags[10:8]), 32'(ef[10:8]));
    chk("R9 fixed bits", 32'({flags[15:12], flags[5], flags[3], flags[1]}), 32'(7'b0000001));
  endtask

  localparam int N_DIRECT = 22;
  localparam int N_TOTAL  = 600;
  int idx = 0;

  // Directed corners; logic ops (R10) at entries 14..19
  task automatic load_next();
    logic [31:0] a, b;
    logic [2:0]  op, ct;
    logic [1:0]  sz;
    logic        c;
    logic [31:0] specials [8];
    specials = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000_0000, 32'hFFFF_FFFF};
    c = 0; ct = 3'b000;
    case (idx)
      0:  begin a = 32'hFF;        b = 32'h1;        op = 0; sz = 0; end
      1:  begin a = 32'h7F;        b = 32'h1;        op = 0; sz = 0; ct = 3'b101; end
      2:  begin a = 32'h7FFF;      b = 32'h1;        op = 0; sz = 1; end
      3:  begin a = 32'hFFFF;      b = 32'h0;        op = 1; sz = 1; c = 1; end
      4:  begin a = 32'h7FFF_FFFF; b = 32'h1;        op = 0; sz = 2; ct = 3'b010; end
      5:  begin a = 32'hFFFF_FFFF; b = 32'h1;        op = 0; sz = 3; end
      6:  begin a = 32'h0;         b = 32'h1;        op = 2; sz = 0; end
      7:  begin a = 32'h8000_0000; b = 32'h1;        op = 2; sz = 2; end
      8:  begin a = 32'h8000;      b = 32'h1;        op = 2; sz = 1; end
      9:  begin a = 32'h5;         b = 32'h5;        op = 3; sz = 0; c = 1; end
      10: begin a = 32'h10;        b = 32'h1;        op = 2; sz = 0; end
      11: begin a = 32'hABCD_1208; b = 32'h8;       op = 0; sz = 0; ct = 3'b111; end
      12: begin a = 32'h0F;        b = 32'h1;        op = 1; sz = 0; c = 1; end
      13: begin a = 32'h1234_0080; b = 32'h80;      op = 3; sz = 0; c = 0; end
      14: begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; op = 4; sz = 2; end
      15: begin a = 32'hF0F0_F0F0; b = 32'h0F0F_0F0F; op = 4; sz = 2; end
      16: begin a = 32'h8000_0000; b = 32'h1;        op = 5; sz = 2; end
      17: begin a = 32'hFF;        b = 32'hFF;       op = 6; sz = 0; end
      18: begin a = 32'h1;         b = 32'h8003;     op = 7; sz = 1; ct = 3'b100; end
      19: begin a = 32'hFFFF_FF00; b = 32'hFF00;     op = 5; sz = 0; end
      20: begin a = 32'h8000;      b = 32'h8000;     op = 0; sz = 1; end
      21: begin a = 32'h8000_0000; b = 32'h8000_0000; op = 3; sz = 2; c = 1; end
      default: begin
        a  = ($urandom % 3 == 0) ? specials[$urandom % 8] : $urandom;
        b  = ($urandom % 3 == 0) ? specials[$urandom % 8] : $urandom;
        op = 3'($urandom % 8);
        sz = 2'($urandom % 4);
        c  = 1'($urandom % 2);
        ct = 3'($urandom % 8);
      end
    endcase
    op_a = a; op_b = b; op_code = op; op_size = sz; carry_in = c; ctrl_in = ct;
    in_valid = (idx < N_TOTAL) && !((idx > N_DIRECT) && (idx % 7 == 3) && ($urandom % 2 == 0));
    if (in_valid) idx++;
  endtask

  int cyc = 0;
  bit acc_prev = 1'b0;
  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 reset out_valid", 32'(out_valid), 32'd0);
    chk("R12 reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 post-reset out_valid", 32'(out_valid), 32'd0);
    acc_prev = 1'b1;
    while (!done) begin
      if (acc_prev || !in_valid) load_next();
      cyc++;
      if ((cyc % 11) >= 8)      out_ready = 1'b0;
      else if ((cyc % 5) == 2)  out_ready = 1'b0;
      else                      out_ready = 1'b1;
      #1;
      chk("R11 in_ready rule", 32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_r_q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected output actual=%h expected=none", result);
        end else begin
          compare_out(exp_r_q.pop_front(), exp_f_q.pop_front());
        end
      end
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        logic [31:0] er;
        logic [15:0] ef;
        model(op_a, op_b, carry_in, op_code, op_size, ctrl_in, er, ef);
        exp_r_q.push_back(er);
        exp_f_q.push_back(ef);
      end
      if (idx >= N_TOTAL && !in_valid && exp_r_q.size() == 0 && !acc_prev) done = 1'b1;
      if (acc_prev && idx >= N_TOTAL) in_valid = 1'b1;
      @(negedge clk);
      if (acc_prev && idx >= N_TOTAL) in_valid = 1'b0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule